// File: doc/BRIEF.md
# Input Period and Gate-Time Counter

This block measures a digital input in one of two ways. With the measurement enable set and the mode select clear, it times the gap between consecutive rising edges of the input in fixed ticks of 200 ns. The tick comes from dividing the system clock. The result is a 24-bit tick count. With both the enable and the mode select set, it opens a repeating gate whose length is given in milliseconds on a window port. It counts the rising edges of the input that fall inside each gate, and reports the count as a 16-bit value in the low bits of the same result port.

The result register changes only when a period completes or a gate closes, so a host never reads a half-built value. A status output tells the host that period timing is running. The input is assumed to be synchronous to `clk` already.

Top module: `edge_meter`

## Requirements
- R1: After a synchronous active-low reset, `result` is 0 and `meas_ack` is 0.
- R2: `meas_ack` is 1 in the cycle after one in which `meas_en`=1 and `gate_sel`=0, and 0 in the cycle after any other combination.
- R3: In period mode, each rising edge of `in_a` after the first loads `result` at that clock edge with the number of ticks since the previous rising edge. One tick is CLK_PER_TICK clock cycles, and the value is an unsigned binary count in all PER_W bits.
- R4: The first rising edge of `in_a` after period mode is entered only starts the timing and leaves `result` unchanged.
- R5: If the interval exceeds 2^PER_W-1 ticks, the next rising edge loads 2^PER_W-1. The interval after that is timed normally from that edge.
- R6: In gate mode, the first gate begins at the first clock edge at which `meas_en`=1 is sampled and lasts `window_ms`×TICKS_PER_MS ticks. At the clock edge that closes the gate, `result` takes the count of rising edges detected in that gate, including one at the closing edge. The count sits in bits CNT_W-1:0, and all higher bits are 0.
- R7: Each gate starts right after the previous one closes, and counts its edges from zero.
- R8: A gate count that would exceed 2^CNT_W-1 reports 2^CNT_W-1.
- R9: A `window_ms` of 0 gives a 1 ms gate.
- R10: While `meas_en`=0, edges on `in_a` have no effect and `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_a | input | 1 | Measured input, synchronous to clk |
| meas_en | input | 1 | Measurement enable |
| gate_sel | input | 1 | 0: period timing, 1: gated edge counting |
| window_ms | input | MS_W | Gate length in milliseconds (0 means 1) |
| result | output | PER_W | Period in ticks, or gate count in low CNT_W bits |
| meas_ack | output | 1 | Period timing active |

## Verification
A period result appears at the same clock edge that detects the closing rising edge. The bench drives each pulse on a falling edge and reads `result` at the next falling edge. It places the edges a whole number of ticks apart, so the expected count is exact whatever the prescaler phase. A gate result appears at the edge `window_ms`×TICKS_PER_MS×CLK_PER_TICK−1 cycles after the enabling edge. The bench counts falling edges from the enable to land just after that edge, and again one gate later. `meas_ack` is due one cycle after the mode inputs change, and it is read at the next falling edge.

// File: rtl/edge_meter_pkg.sv
// Shared types for the edge meter: the measurement mode and its decode.
package edge_meter_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_PERIOD = 2'd1,
        MODE_GATE   = 2'd2
    } meter_mode_t;

    // Decode enable and select into one mode value.
    function automatic meter_mode_t decode_mode(input logic en, input logic gate);
        if (!en)       return MODE_OFF;
        else if (gate) return MODE_GATE;
        else           return MODE_PERIOD;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
// Divides clk into a one-cycle tick every DIV cycles while enabled.
// Assumes DIV >= 2. The phase restarts from zero whenever en drops.
module tick_prescaler #(
    parameter int DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    // Cycle counter wrapping at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3
endmodule

// File: rtl/period_timer.sv
// Times the ticks between rising edges. The first edge after enable only arms it.
// The running count saturates at all ones. The capture value includes a tick
// that lands on the closing edge.
module period_timer #(
    parameter int PER_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             rise,
    output logic             cap,
    output logic [PER_W-1:0] cap_val
);
    localparam logic [PER_W-1:0] MAX = '1;

    logic [PER_W-1:0] timer;
    logic             armed;
    logic             bump;

    assign bump    = tick && (timer != MAX);
    assign cap_val = bump ? timer + 1'b1 : timer;
    assign cap     = en && rise && armed;

    // Running interval count and arming flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            timer <= '0;
            armed <= 1'b0;
        end else if (rise) begin
            timer <= '0;
            armed <= 1'b1;
        end else if (bump) begin
            timer <= timer + 1'b1;
        end
    end

    AST_TIMER_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !rise && timer == MAX) |=> (timer == MAX)); // R5
endmodule

// File: rtl/gate_counter.sv
// Counts rising edges inside back-to-back gates of window_ms milliseconds.
// Assumes TICKS_PER_MS >= 2. A zero window is read as 1 ms.
module gate_counter #(
    parameter int CNT_W        = 16,
    parameter int MS_W         = 16,
    parameter int TICKS_PER_MS = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             rise,
    input  logic [MS_W-1:0]  window_ms,
    output logic             done,
    output logic [CNT_W-1:0] count_val
);
    localparam int SUB_W = $clog2(TICKS_PER_MS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_MS - 1);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [SUB_W-1:0] sub;
    logic [MS_W-1:0]  ms;
    logic [CNT_W-1:0] pcount;
    logic [MS_W-1:0]  last_ms;
    logic             ms_end;

    assign last_ms   = (window_ms == '0) ? '0 : window_ms - 1'b1;
    assign ms_end    = tick && (sub == SUB_LAST);
    assign done      = en && ms_end && (ms >= last_ms);
    assign count_val = (rise && pcount != CMAX) ? pcount + 1'b1 : pcount;

    // Tick-within-millisecond and millisecond-within-gate counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sub <= '0;
            ms  <= '0;
        end else if (ms_end) begin
            sub <= '0;
            ms  <= done ? '0 : ms + 1'b1;
        end else if (tick) begin
            sub <= sub + 1'b1;
        end
    end

    // Saturating edge count, cleared as each gate closes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) pcount <= '0;
        else if (done)     pcount <= '0;
        else               pcount <= count_val;
    end

    AST_GATE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rise) |=> (pcount == '0 || !$past(en))); // R7
endmodule

// File: rtl/edge_meter.sv
// Top of the edge meter: edge detect, mode decode, shared result register and
// status. Assumes in_a is already synchronous to clk and CNT_W <= PER_W.
module edge_meter
    import edge_meter_pkg::*;
#(
    parameter int CLK_PER_TICK = 25,
    parameter int TICKS_PER_MS = 5000,
    parameter int PER_W        = 24,
    parameter int CNT_W        = 16,
    parameter int MS_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_a,
    input  logic             meas_en,
    input  logic             gate_sel,
    input  logic [MS_W-1:0]  window_ms,
    output logic [PER_W-1:0] result,
    output logic             meas_ack
);
    meter_mode_t      mode;
    logic             a_q;
    logic             rise;
    logic             tick;
    logic             per_cap;
    logic [PER_W-1:0] per_val;
    logic             gate_done;
    logic [CNT_W-1:0] gate_val;

    assign mode = decode_mode(meas_en, gate_sel);
    assign rise = in_a && !a_q;

    // Previous input level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= 1'b0;
        else        a_q <= in_a;
    end

    tick_prescaler #(.DIV(CLK_PER_TICK)) u_presc (
        .clk(clk), .rst_n(rst_n), .en(mode != MODE_OFF), .tick(tick)
    );

    period_timer #(.PER_W(PER_W)) u_period (
        .clk(clk), .rst_n(rst_n), .en(mode == MODE_PERIOD), .tick(tick),
        .rise(rise), .cap(per_cap), .cap_val(per_val)
    );

    gate_counter #(.CNT_W(CNT_W), .MS_W(MS_W), .TICKS_PER_MS(TICKS_PER_MS)) u_gate (
        .clk(clk), .rst_n(rst_n), .en(mode == MODE_GATE), .tick(tick),
        .rise(rise), .window_ms(window_ms), .done(gate_done), .count_val(gate_val)
    );

    // Result register, written only at a completed measurement.
    always_ff @(posedge clk) begin
        if (!rst_n)         result <= '0;
        else if (per_cap)   result <= per_val;
        else if (gate_done) result <= PER_W'(gate_val);
    end

    // Status: period timing was selected last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) meas_ack <= 1'b0;
        else        meas_ack <= (mode == MODE_PERIOD);
    end

    AST_CAP_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        per_cap |-> meas_ack); // R4
    AST_GATE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        gate_done |-> !meas_ack); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_cap && !gate_done) |=> $stable(result)); // R10
    AST_GATE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        gate_done |=> ((result >> CNT_W) == '0)); // R8
endmodule

// File: tb/edge_meter_tb.sv
module edge_meter_tb;
    localparam int DIV = 4;
    localparam int TPM = 5;
    localparam int PW  = 8;
    localparam int CW  = 4;
    localparam int MW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_a = 1'b0;
    logic          meas_en = 1'b0;
    logic          gate_sel = 1'b0;
    logic [MW-1:0] window_ms = '0;
    logic [PW-1:0] result;
    logic          meas_ack;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    edge_meter #(.CLK_PER_TICK(DIV), .TICKS_PER_MS(TPM), .PER_W(PW),
                 .CNT_W(CW), .MS_W(MW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .meas_en(meas_en),
        .gate_sel(gate_sel), .window_ms(window_ms), .result(result),
        .meas_ack(meas_ack)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One-cycle high pulse: the rise is seen at the next posedge.
    task automatic pulse();
        in_a = 1'b1;
        @(negedge clk);
        in_a = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int last;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 result", int'(result), 0);
        check("R1 ack", int'(meas_ack), 0);

        // Period mode: ack, arming, chained intervals.
        meas_en = 1'b1; gate_sel = 1'b0;
        @(negedge clk);
        check("R2 ack on", int'(meas_ack), 1);
        repeat (3) @(negedge clk);
        pulse();
        check("R4 arm only", int'(result), 0);
        for (int k = 1; k <= 30; k++) begin
            repeat (k*DIV - 1) @(negedge clk);
            pulse();
            check("R3 period", int'(result), k);
        end
        repeat (300*DIV - 1) @(negedge clk);
        pulse();
        check("R5 saturate", int'(result), 255);
        repeat (5*DIV - 1) @(negedge clk);
        pulse();
        check("R5 after sat", int'(result), 5);

        // Disabled: edges ignored.
        meas_en = 1'b0;
        @(negedge clk);
        check("R2 ack off", int'(meas_ack), 0);
        last = int'(result);
        for (int i = 0; i < 6; i++) begin
            pulse();
            repeat (3) @(negedge clk);
        end
        check("R10 hold", int'(result), last);

        // Gate mode sweep.
        for (int w = 0; w <= 3; w++) begin
            int clocks;
            int maxn;
            clocks = ((w == 0) ? 1 : w) * TPM * DIV;
            maxn = (clocks + 1) / 2;
            for (int n = 0; n <= maxn; n++) begin
                window_ms = MW'(w);
                gate_sel = 1'b1;
                meas_en = 1'b1;
                @(negedge clk);
                check("R2 ack gate", int'(meas_ack), 0);
                for (int i = 0; i < n; i++) begin
                    in_a = 1'b1;
                    @(negedge clk);
                    in_a = 1'b0;
                    if (i != n - 1 || 2*n <= clocks) @(negedge clk);
                end
                while (2*n < clocks && 0) @(negedge clk);
                repeat (clocks - 1 - ((n == 0) ? 0 : ((2*n <= clocks) ? 2*n - 1 : 2*n - 2))) @(negedge clk);
                if (w == 0) check("R9 zero window", int'(result), (n > 15) ? 15 : n);
                else if (n > 15) check("R8 count sat", int'(result), 15);
                else check("R6 gate count", int'(result), n);
                repeat (clocks) @(negedge clk);
                check("R7 next gate", int'(result), 0);
                meas_en = 1'b0;
                @(negedge clk);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule